// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block caches recent virtual-to-physical page translations so that a memory access can skip the page-table walk. Every slot holds a process identifier, a virtual page number, a physical page number and a few metadata bits. A lookup compares the presented process identifier and virtual page number against all slots at once. The hit flag, the physical page number and the metadata come back combinationally in the same cycle. Pages are 4 KB, so the 12-bit page offset never enters the block; only page numbers are presented.

Because each slot carries its process identifier, mappings from several processes can sit side by side. A context switch therefore needs no invalidation. A fill port installs the result of a walk. It rewrites a slot that already holds the same pair, otherwise it takes the lowest-numbered empty slot, and otherwise it evicts in round-robin order. Two flush commands are provided. One clears the slots of a single process, for use when that identifier is about to be reused. The other clears everything.

Top module: `pid_tlb`

## Requirements
- R1: After the asynchronous reset, every slot is empty and every lookup misses.
- R2: A lookup hits only when a valid slot matches both the process identifier and the virtual page number. On a hit, ppn_o and meta_o carry that slot's contents in the same cycle. On a miss, hit_o, ppn_o and meta_o are all zero.
- R3: The same virtual page number under different process identifiers can be resident at the same time, each pair returning its own physical page number.
- R4: A fill accepted on a clock edge is visible to lookups from the following cycle onward.
- R5: A fill whose pair is already resident overwrites that slot in place. It consumes no other slot and does not advance the replacement pointer.
- R6: A fill of a new pair, made while any slot is empty, goes to the lowest-numbered empty slot and does not advance the replacement pointer.
- R7: A fill of a new pair into a full table evicts the slot under the replacement pointer. The pointer is 0 after reset and advances by one after each eviction, wrapping from ENTRIES-1 to 0.
- R8: flush_op_i = 2'b01 clears every slot whose process identifier equals flush_pid_i and leaves all other slots intact.
- R9: flush_op_i = 2'b10 clears every slot. The codes 2'b00 and 2'b11 change nothing.
- R10: A fill presented in the same cycle as a flush (code 2'b01 or 2'b10) is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_pid_i | input | PID_W | Lookup process identifier |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| hit_o | output | 1 | Lookup hit |
| ppn_o | output | PPN_W | Physical page number on a hit, zero otherwise |
| meta_o | output | META_W | Metadata on a hit, zero otherwise |
| fill_valid_i | input | 1 | Install a translation on this edge |
| fill_pid_i | input | PID_W | Fill process identifier |
| fill_vpn_i | input | VPN_W | Fill virtual page number |
| fill_ppn_i | input | PPN_W | Fill physical page number |
| fill_meta_i | input | META_W | Fill metadata |
| flush_op_i | input | 2 | 00 none, 01 by process, 10 all, 11 none |
| flush_pid_i | input | PID_W | Process identifier for flush by process |

## Verification
The bench installs one virtual page under two process identifiers and checks that each pair returns its own frame. A design that compared only the page number would return the wrong frame for one of them. It then fills the table until it is full and follows the eviction order. A refill of a resident pair must not evict the slot under the pointer, and a fill into a hole left by a per-process flush must not advance the pointer. A design that duplicated entries, or that ignored empty slots, would lose a mapping that the bench expects to remain. The bench also issues a flush and a fill in the same cycle, and sends the unused flush code, to catch a fill that slips past a flush or a spurious invalidation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FLUSH_NONE = 2'b00,
    FLUSH_PID  = 2'b01,
    FLUSH_ALL  = 2'b10,
    FLUSH_RSVD = 2'b11
  } flush_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 32,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][PID_W-1:0] pid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0]              key_pid_i,
  input  logic [VPN_W-1:0]              key_vpn_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (pid_i[g] == key_pid_i) && (vpn_i[g] == key_vpn_i);
  end
endmodule

// File: rtl/tlb_sel.sv
module tlb_sel #(
  parameter int ENTRIES = 32,
  parameter int W       = 24
) (
  input  logic [ENTRIES-1:0]        sel_i,
  input  logic [ENTRIES-1:0][W-1:0] data_i,
  output logic [W-1:0]              data_o
);
  // one-hot and-or mux; all-zero select yields zero
  always_comb begin
    data_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      data_o = data_o | (data_i[i] & {W{sel_i[i]}});
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] upd_i,
  input  logic [IDX_W-1:0]   rr_ptr_i,
  output logic [ENTRIES-1:0] victim_o,
  output logic               evict_o
);
  logic [ENTRIES-1:0] free_oh;
  logic               found;

  always_comb begin
    free_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  // priority: in-place update, then empty slot, then round-robin
  always_comb begin
    victim_o = '0;
    evict_o  = 1'b0;
    if (|upd_i) begin
      victim_o = upd_i;
    end else if (found) begin
      victim_o = free_oh;
    end else begin
      victim_o[rr_ptr_i] = 1'b1;
      evict_o            = 1'b1;
    end
  end
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int META_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PID_W-1:0]  lk_pid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [META_W-1:0] meta_o,
  input  logic              fill_valid_i,
  input  logic [PID_W-1:0]  fill_pid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [META_W-1:0] fill_meta_i,
  input  logic [1:0]        flush_op_i,
  input  logic [PID_W-1:0]  flush_pid_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PAY_W = PPN_W + META_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][PID_W-1:0]  pid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PAY_W-1:0]  pay_q;
  logic [IDX_W-1:0]               rr_q;

  logic [ENTRIES-1:0] lk_vec, upd_vec, victim_oh, clr_vec;
  logic               evict, flush_act, fill_en;
  flush_op_e          op;

  tlb_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_lk_match (
    .valid_i(valid_q), .pid_i(pid_q), .vpn_i(vpn_q),
    .key_pid_i(lk_pid_i), .key_vpn_i(lk_vpn_i), .match_o(lk_vec)
  );

  tlb_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_fill_match (
    .valid_i(valid_q), .pid_i(pid_q), .vpn_i(vpn_q),
    .key_pid_i(fill_pid_i), .key_vpn_i(fill_vpn_i), .match_o(upd_vec)
  );

  tlb_sel #(.ENTRIES(ENTRIES), .W(PAY_W)) u_sel (
    .sel_i(lk_vec), .data_i(pay_q), .data_o({ppn_o, meta_o})
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i(valid_q), .upd_i(upd_vec), .rr_ptr_i(rr_q),
    .victim_o(victim_oh), .evict_o(evict)
  );

  assign hit_o     = |lk_vec;
  assign op        = flush_op_e'(flush_op_i);
  assign flush_act = (op == FLUSH_PID) || (op == FLUSH_ALL);
  assign fill_en   = fill_valid_i && !flush_act;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_clr
    assign clr_vec[g] = (op == FLUSH_ALL) || ((op == FLUSH_PID) && (pid_q[g] == flush_pid_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      pid_q   <= '0;
      vpn_q   <= '0;
      pay_q   <= '0;
      rr_q    <= '0;
    end else if (flush_act) begin
      valid_q <= valid_q & ~clr_vec;
    end else if (fill_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (victim_oh[i]) begin
          valid_q[i] <= 1'b1;
          pid_q[i]   <= fill_pid_i;
          vpn_q[i]   <= fill_vpn_i;
          pay_q[i]   <= {fill_ppn_i, fill_meta_i};
        end
      end
      if (evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int ENTRIES = 32,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int META_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PID_W-1:0]  lk_pid_i,
  input logic [VPN_W-1:0]  lk_vpn_i,
  input logic              hit_o,
  input logic [PPN_W-1:0]  ppn_o,
  input logic [META_W-1:0] meta_o,
  input logic              fill_valid_i,
  input logic [PID_W-1:0]  fill_pid_i,
  input logic [VPN_W-1:0]  fill_vpn_i,
  input logic [PPN_W-1:0]  fill_ppn_i,
  input logic [1:0]        flush_op_i,
  input logic [PID_W-1:0]  flush_pid_i,
  input logic [ENTRIES-1:0] lk_vec
);
  AST_UNIQUE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec)); // R5

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ppn_o == '0 && meta_o == '0)); // R2

  AST_FILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && flush_op_i != 2'b01 && flush_op_i != 2'b10) |=>
      ((lk_pid_i != $past(fill_pid_i)) || (lk_vpn_i != $past(fill_vpn_i)) ||
       (hit_o && ppn_o == $past(fill_ppn_i)))); // R4

  AST_FLUSH_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i == 2'b10) |=> !hit_o); // R9

  AST_FLUSH_PID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_op_i == 2'b01) |=> !(hit_o && lk_pid_i == $past(flush_pid_i))); // R8
endmodule

bind pid_tlb tlb_checker #(
  .ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .META_W(META_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_pid_i(lk_pid_i), .lk_vpn_i(lk_vpn_i),
  .hit_o(hit_o), .ppn_o(ppn_o), .meta_o(meta_o), .fill_valid_i(fill_valid_i),
  .fill_pid_i(fill_pid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
  .flush_op_i(flush_op_i), .flush_pid_i(flush_pid_i), .lk_vec(lk_vec)
);

// File: tb/tb_pid_tlb.sv
module tb_pid_tlb;
  localparam int PID_W = 8, VPN_W = 20, PPN_W = 20, META_W = 4;

  typedef struct packed {
    logic [PID_W-1:0]  pid;
    logic [VPN_W-1:0]  vpn;
    logic              hit;
    logic [PPN_W-1:0]  ppn;
    logic [META_W-1:0] meta;
    logic [3:0]        req;
  } tv_t;

  localparam int NV = 7;
  localparam tv_t TBL [NV] = '{
    '{8'd0, 20'd8,       1'b1, 20'd28,      4'd1, 4'd3},  // R3
    '{8'd1, 20'd8,       1'b1, 20'd44,      4'd2, 4'd3},  // R3
    '{8'd2, 20'd8,       1'b0, 20'd0,       4'd0, 4'd2},  // R2
    '{8'd0, 20'd9,       1'b1, 20'd30,      4'd3, 4'd2},  // R2
    '{8'd1, 20'd9,       1'b0, 20'd0,       4'd0, 4'd2},  // R2
    '{8'd2, 20'h12345,   1'b1, 20'hABCDE,   4'd4, 4'd2},  // R2
    '{8'd3, 20'h12345,   1'b0, 20'd0,       4'd0, 4'd2}   // R2
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [PID_W-1:0]  lk_pid = '0, fill_pid = '0, flush_pid = '0;
  logic [VPN_W-1:0]  lk_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0]  fill_ppn = '0, ppn;
  logic [META_W-1:0] fill_meta = '0, meta;
  logic              fill_valid = 1'b0, hit;
  logic [1:0]        flush_op = 2'b00;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pid_tlb dut (
    .clk_i(clk), .rst_ni(rst_ni), .lk_pid_i(lk_pid), .lk_vpn_i(lk_vpn),
    .hit_o(hit), .ppn_o(ppn), .meta_o(meta), .fill_valid_i(fill_valid),
    .fill_pid_i(fill_pid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_meta_i(fill_meta), .flush_op_i(flush_op), .flush_pid_i(flush_pid)
  );

  task automatic look(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                      input logic eh, input logic [PPN_W-1:0] ep, input string req);
    @(negedge clk);
    lk_pid = p; lk_vpn = v;
    #1;
    checks++;
    if (hit !== eh || ppn !== (eh ? ep : '0)) begin
      errors++;
      $display("FAIL %s pid=%0d vpn=%0h: hit=%b ppn=%0h expected hit=%b ppn=%0h",
               req, p, v, hit, ppn, eh, eh ? ep : '0);
    end
  endtask

  task automatic fill(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                      input logic [PPN_W-1:0] pp, input logic [META_W-1:0] m,
                      input logic [1:0] fop);
    @(negedge clk);
    fill_valid = 1'b1; fill_pid = p; fill_vpn = v; fill_ppn = pp; fill_meta = m;
    flush_op = fop;
    @(negedge clk);
    fill_valid = 1'b0; flush_op = 2'b00;
  endtask

  task automatic flush(input logic [1:0] fop, input logic [PID_W-1:0] p);
    @(negedge clk);
    flush_op = fop; flush_pid = p;
    @(negedge clk);
    flush_op = 2'b00;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    look(8'd0, 20'd0, 1'b0, '0, "R1");

    fill(8'd0, 20'd8, 20'd28, 4'd1, 2'b00);
    fill(8'd1, 20'd8, 20'd44, 4'd2, 2'b00);
    fill(8'd0, 20'd9, 20'd30, 4'd3, 2'b00);
    fill(8'd2, 20'h12345, 20'hABCDE, 4'd4, 2'b00);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      lk_pid = TBL[i].pid; lk_vpn = TBL[i].vpn;
      #1;
      checks++;
      if (hit !== TBL[i].hit || ppn !== TBL[i].ppn || meta !== TBL[i].meta) begin
        errors++;
        $display("FAIL R%0d vector %0d: hit=%b ppn=%0h meta=%0h expected hit=%b ppn=%0h meta=%0h",
                 TBL[i].req, i, hit, ppn, meta, TBL[i].hit, TBL[i].ppn, TBL[i].meta);
      end
    end

    // R4: visible the cycle after the fill edge
    @(negedge clk);
    fill_valid = 1'b1; fill_pid = 8'd9; fill_vpn = 20'd77; fill_ppn = 20'd7; fill_meta = 4'd5;
    lk_pid = 8'd9; lk_vpn = 20'd77;
    #1;
    checks++;
    if (hit !== 1'b0) begin errors++; $display("FAIL R4 early hit=%b expected 0", hit); end
    @(negedge clk);
    fill_valid = 1'b0;
    #1;
    checks++;
    if (hit !== 1'b1 || ppn !== 20'd7) begin
      errors++; $display("FAIL R4 hit=%b ppn=%0h expected 1 7", hit, ppn);
    end

    flush(2'b11, 8'd0);                              // R9 reserved code
    look(8'd0, 20'd8, 1'b1, 20'd28, "R9");
    flush(2'b01, 8'd0);                              // R8
    look(8'd0, 20'd8, 1'b0, '0, "R8");
    look(8'd0, 20'd9, 1'b0, '0, "R8");
    look(8'd1, 20'd8, 1'b1, 20'd44, "R8");
    flush(2'b10, 8'd0);                              // R9
    look(8'd1, 20'd8, 1'b0, '0, "R9");
    look(8'd2, 20'h12345, 1'b0, '0, "R9");
    fill(8'd5, 20'd5, 20'd55, 4'd0, 2'b10);          // R10
    look(8'd5, 20'd5, 1'b0, '0, "R10");

    // R6: fill to full, slot 20 belongs to pid 8
    for (int i = 0; i < 32; i++)
      fill((i == 20) ? 8'd8 : 8'd7, 20'(i), 20'(i + 100), 4'd0, 2'b00);
    look(8'd7, 20'd0, 1'b1, 20'd100, "R6");
    look(8'd7, 20'd31, 1'b1, 20'd131, "R6");
    // R7: evictions follow pointer 0 then 1
    fill(8'd7, 20'd40, 20'd140, 4'd0, 2'b00);
    look(8'd7, 20'd0, 1'b0, '0, "R7");
    look(8'd7, 20'd1, 1'b1, 20'd101, "R7");
    look(8'd7, 20'd40, 1'b1, 20'd140, "R7");
    fill(8'd7, 20'd41, 20'd141, 4'd0, 2'b00);
    look(8'd7, 20'd1, 1'b0, '0, "R7");
    look(8'd7, 20'd2, 1'b1, 20'd102, "R7");
    // R5: in-place refill must spare the slot under the pointer
    fill(8'd7, 20'd10, 20'd555, 4'd0, 2'b00);
    look(8'd7, 20'd10, 1'b1, 20'd555, "R5");
    look(8'd7, 20'd2, 1'b1, 20'd102, "R5");
    // R6: hole from flush is reused before eviction
    flush(2'b01, 8'd8);
    look(8'd8, 20'd20, 1'b0, '0, "R8");
    look(8'd7, 20'd21, 1'b1, 20'd121, "R8");
    fill(8'd7, 20'd50, 20'd150, 4'd0, 2'b00);
    look(8'd7, 20'd50, 1'b1, 20'd150, "R6");
    look(8'd7, 20'd2, 1'b1, 20'd102, "R6");
    // R7: pointer still at 2
    fill(8'd7, 20'd51, 20'd151, 4'd0, 2'b00);
    look(8'd7, 20'd2, 1'b0, '0, "R7");
    look(8'd7, 20'd3, 1'b1, 20'd103, "R7");
    look(8'd7, 20'd51, 1'b1, 20'd151, "R7");

    finish_run();
  end
endmodule